// File: doc/BRIEF.md
# System Control Register Bank

This block holds the architectural state of a processor's system control coprocessor: the translation entry staging registers, status, exception return address, configuration, watch and cache tag registers, together with a free-running cycle counter, its match register and a victim-selection counter. A single write port selects a register by a 5-bit number. Every register applies its own write rule: some fields are masked away, one register merges new high bits with its existing low bits, some numbers drop the write, one accepts only zero, one is forced to zero, and numbers with no register behind them flag an error.

The counter advances on a `tick` pulse. When an advance makes it equal to the match register, the timer-pending bit (bit 15 of the cause register) rises and is also driven on `timer_irq`. It stays set until the match register is written. The victim counter steps down on each `retire` pulse and reloads from its top value once it has reached the floor held in the wired register. Reads are combinational and return the selected 32-bit value sign-extended to 64 bits.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset every register reads zero, except the victim counter (number 1), which reads 31. `wr_err` and `timer_irq` are low.
- R2: A write takes effect at the next clock edge and changes only the bits inside that register's mask. The masks are: number 0 0x8000003F; numbers 2 and 3 0x3FFFFFFF; number 5 0x01FFE000; number 10 0xFFFFE0FF; number 28 0x0FFFFFC0. Numbers 6, 11, 12, 14, 16, 18 and 19 take all 32 bits.
- R3: A write to number 4 replaces bits 31:23 only. Bits 22:0 keep their previous value.
- R4: A write to number 0 whose bits 5:0 exceed 31 (that is, bit 5 set) is still stored under the mask, and `wr_err` is high for exactly the following cycle.
- R5: Writes to numbers 1, 8, 15 and 27 change nothing and raise no error. Number 29 reads zero after any write and raises no error.
- R6: Writing zero to number 13 clears it. A nonzero write leaves it unchanged and raises `wr_err` for the following cycle.
- R7: A write to any of numbers 7, 17, 20 to 26, 30 and 31 raises `wr_err` for the following cycle and changes no state. These numbers always read zero.
- R8: The counter (number 9) increases by one at each clock edge where `tick` is high. A write to number 9 loads the written value at the next edge, and a `tick` in that same cycle is dropped.
- R9: When a tick makes the counter equal to number 11, cause bit 15 and `timer_irq` rise at that edge and stay high until number 11 is written. A write to number 11 clears the bit, even when a match occurs in the same cycle. A zero write to number 13 also clears the bit, unless a match occurs in the same cycle.
- R10: On `retire`, the victim counter steps down by one. If its value is already less than or equal to the wired register (number 6), it reloads 31 instead. A write to number 6 forces it to 31, and that write takes priority over a `retire` in the same cycle.
- R11: `rd_data` shows the register selected by `rd_sel` in the same cycle, as the 32-bit value with bit 31 copied into bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 5 | Register number to write |
| wr_data | input | 32 | Write value |
| rd_sel | input | 5 | Register number to read |
| rd_data | output | 64 | Sign-extended read value |
| tick | input | 1 | Counter advance pulse |
| retire | input | 1 | Victim counter step pulse |
| wr_err | output | 1 | High for one cycle after an illegal write |
| timer_irq | output | 1 | Timer-pending bit (cause bit 15) |

## Verification
The assertions check, on every cycle, that the counter steps or loads exactly as requested, that a match-register write leaves the pending bit low, that the pending bit holds while nothing clears it, that the victim counter stays within range and reloads on a wired write, and that each class of illegal write produces the error pulse. Some behaviour appears only in the bench's scenarios and its reference model: the exact value kept by every masked and merged register, the reload sequence of the victim counter against different wired floors, the ordering of a match against clears in the same cycle, and the sign extension of every readable number.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN        = 32;
    localparam int RLEN        = 64;
    localparam int NSEL        = 32;
    localparam int SEL_W       = $clog2(NSEL);
    localparam int TLB_SLOTS   = 32;
    localparam int SLOT_FIELD  = 6;
    localparam int PEND_BIT    = 15;

    localparam int N_SLOT      = 0;
    localparam int N_VICTIM    = 1;
    localparam int N_LO_EVEN   = 2;
    localparam int N_LO_ODD    = 3;
    localparam int N_PTBASE    = 4;
    localparam int N_PGSIZE    = 5;
    localparam int N_FLOOR     = 6;
    localparam int N_FAULTVA   = 8;
    localparam int N_TIMER     = 9;
    localparam int N_VPNHI     = 10;
    localparam int N_MATCH     = 11;
    localparam int N_STATE     = 12;
    localparam int N_REASON    = 13;
    localparam int N_RETPC     = 14;
    localparam int N_IDENT     = 15;
    localparam int N_CFG       = 16;
    localparam int N_WPT_LO    = 18;
    localparam int N_WPT_HI    = 19;
    localparam int N_CERR      = 27;
    localparam int N_TAG_LO    = 28;
    localparam int N_TAG_HI    = 29;

    typedef enum logic [2:0] {
        WP_STORE,
        WP_IGNORE,
        WP_FAULT,
        WP_TIMER,
        WP_REASON,
        WP_ZERO
    } wpol_e;

    function automatic wpol_e wpol(input int unsigned sel);
        case (sel)
            N_SLOT, N_LO_EVEN, N_LO_ODD, N_PTBASE, N_PGSIZE, N_FLOOR,
            N_VPNHI, N_MATCH, N_STATE, N_RETPC, N_CFG, N_WPT_LO,
            N_WPT_HI, N_TAG_LO:                     return WP_STORE;
            N_VICTIM, N_FAULTVA, N_IDENT, N_CERR:   return WP_IGNORE;
            N_TIMER:                                return WP_TIMER;
            N_REASON:                               return WP_REASON;
            N_TAG_HI:                               return WP_ZERO;
            default:                                return WP_FAULT;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] wmask(input int unsigned sel);
        case (sel)
            N_SLOT:               return 32'h8000_003F;
            N_LO_EVEN, N_LO_ODD:  return 32'h3FFF_FFFF;
            N_PTBASE:             return 32'hFF80_0000;
            N_PGSIZE:             return 32'h01FF_E000;
            N_VPNHI:              return 32'hFFFF_E0FF;
            N_TAG_LO:             return 32'h0FFF_FFC0;
            default:              return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_store_bank.sv
module sysctl_store_bank
    import sysctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [XLEN-1:0]      wr_data,
    output logic [XLEN-1:0]      bank [NSEL]
);

    for (genvar gi = 0; gi < NSEL; gi++) begin : g_ent
        if (wpol(gi) == WP_STORE) begin : g_store
            localparam logic [XLEN-1:0] KEEP = wmask(gi);
            logic [XLEN-1:0] val_d, val_q;

            always_comb begin
                val_d = val_q;
                if (wr_en && (wr_sel == SEL_W'(gi)))
                    val_d = (val_q & ~KEEP) | (wr_data & KEEP);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end

            assign bank[gi] = val_q;
        end else begin : g_none
            assign bank[gi] = '0;
        end
    end

endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [XLEN-1:0]  load_val,
    input  logic [XLEN-1:0]  match_val,
    input  logic             match_wr,
    input  logic             reason_clr,
    output logic [XLEN-1:0]  count,
    output logic             pending
);

    typedef struct packed {
        logic [XLEN-1:0] cnt;
        logic            pend;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic hit;

    always_comb begin
        tmr_d = tmr_q;
        hit   = 1'b0;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tick) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            hit       = (tmr_d.cnt == match_val);
        end
        if (match_wr)        tmr_d.pend = 1'b0;
        else if (hit)        tmr_d.pend = 1'b1;
        else if (reason_clr) tmr_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign count   = tmr_q.cnt;
    assign pending = tmr_q.pend;

    a_r8_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (count == $past(count) + 1'b1));
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
    a_r9_match_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        match_wr |=> !pending);
    a_r9_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !match_wr && !reason_clr) |=> pending);

endmodule

// File: rtl/sysctl_victim.sv
module sysctl_victim
    import sysctl_pkg::*;
#(
    parameter int TOP = TLB_SLOTS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic             floor_wr,
    input  logic [XLEN-1:0]  floor_val,
    output logic [XLEN-1:0]  victim
);

    localparam int VW = $clog2(TOP + 1);
    localparam logic [VW-1:0] TOP_V = VW'(TOP);

    typedef struct packed {
        logic [VW-1:0] idx;
    } vic_t;

    vic_t vic_d, vic_q;
    logic [XLEN-1:0] wide;

    assign wide = {{(XLEN-VW){1'b0}}, vic_q.idx};

    always_comb begin
        vic_d = vic_q;
        if (floor_wr)
            vic_d.idx = TOP_V;
        else if (retire)
            vic_d.idx = (wide <= floor_val) ? TOP_V : vic_q.idx - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vic_q.idx <= TOP_V;
        else        vic_q     <= vic_d;
    end

    assign victim = wide;

    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        victim <= XLEN'(TOP));
    a_r10_floor_reload: assert property (@(posedge clk) disable iff (!rst_n)
        floor_wr |=> (victim == XLEN'(TOP)));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!floor_wr && !retire) |=> $stable(victim));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int VICTIM_TOP = TLB_SLOTS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [RLEN-1:0]   rd_data,
    input  logic              tick,
    input  logic              retire,
    output logic              wr_err,
    output logic              timer_irq
);

    typedef struct packed {
        logic err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [XLEN-1:0] bank [NSEL];
    logic [XLEN-1:0] count, victim, reason, rd_word;
    logic            pending;
    wpol_e           pol;
    logic            timer_ld, match_wr, floor_wr, reason_clr, slot_bad;

    assign pol        = wpol(32'(wr_sel));
    assign timer_ld   = wr_en && (pol == WP_TIMER);
    assign match_wr   = wr_en && (wr_sel == SEL_W'(N_MATCH));
    assign floor_wr   = wr_en && (wr_sel == SEL_W'(N_FLOOR));
    assign reason_clr = wr_en && (pol == WP_REASON) && (wr_data == '0);
    assign slot_bad   = wr_data[SLOT_FIELD-1:0] > SLOT_FIELD'(TLB_SLOTS - 1);

    sysctl_store_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .bank    (bank)
    );

    sysctl_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (timer_ld),
        .load_val   (wr_data),
        .match_val  (bank[N_MATCH]),
        .match_wr   (match_wr),
        .reason_clr (reason_clr),
        .count      (count),
        .pending    (pending)
    );

    sysctl_victim #(.TOP(VICTIM_TOP)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire    (retire),
        .floor_wr  (floor_wr),
        .floor_val (bank[N_FLOOR]),
        .victim    (victim)
    );

    always_comb begin
        ctl_d.err = 1'b0;
        if (wr_en) begin
            case (pol)
                WP_FAULT:  ctl_d.err = 1'b1;
                WP_REASON: ctl_d.err = (wr_data != '0);
                WP_STORE:  ctl_d.err = (wr_sel == SEL_W'(N_SLOT)) && slot_bad;
                default:   ctl_d.err = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reason           = '0;
        reason[PEND_BIT] = pending;
        case (32'(rd_sel))
            N_VICTIM: rd_word = victim;
            N_TIMER:  rd_word = count;
            N_REASON: rd_word = reason;
            default:  rd_word = bank[rd_sel];
        endcase
    end

    assign rd_data   = {{(RLEN-XLEN){rd_word[XLEN-1]}}, rd_word};
    assign wr_err    = ctl_q.err;
    assign timer_irq = pending;

    a_r4_slot_range_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(N_SLOT) && wr_data[5]) |=> wr_err);
    a_r6_reason_nonzero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(N_REASON) && wr_data != '0) |=> wr_err);
    a_r5_dropped_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_W'(N_VICTIM) || wr_sel == SEL_W'(N_FAULTVA) ||
                   wr_sel == SEL_W'(N_IDENT)  || wr_sel == SEL_W'(N_CERR)   ||
                   wr_sel == SEL_W'(N_TAG_HI))) |=> !wr_err);
    a_r7_unlisted_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 5'd7 || wr_sel == 5'd17 || wr_sel >= 5'd30 ||
                   (wr_sel >= 5'd20 && wr_sel <= 5'd26))) |=> wr_err);
    a_r1_no_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);
    a_r11_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RLEN-1:XLEN] == {(RLEN-XLEN){rd_data[XLEN-1]}});

endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        tick = 1'b0;
    logic        retire = 1'b0;
    logic        wr_err;
    logic        timer_irq;

    always #4 clk = ~clk;

    sysctl_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .tick(tick), .retire(retire), .wr_err(wr_err), .timer_irq(timer_irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_reg [32];
    logic [31:0] m_cnt;
    logic [31:0] m_vic;
    logic        m_pend;
    logic        m_err;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int kind(input int s);
        if (s inside {0, 2, 3, 4, 5, 6, 10, 11, 12, 14, 16, 18, 19, 28}) return 0;
        if (s inside {1, 8, 15, 27, 29}) return 1;
        if (s == 9) return 2;
        if (s == 13) return 3;
        return 4;
    endfunction

    function automatic logic [31:0] msk(input int s);
        case (s)
            0:       return 32'h8000003F;
            2, 3:    return 32'h3FFFFFFF;
            4:       return 32'hFF800000;
            5:       return 32'h01FFE000;
            10:      return 32'hFFFFE0FF;
            28:      return 32'h0FFFFFC0;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    function automatic logic [31:0] mread(input int s);
        if (s == 1)  return m_vic;
        if (s == 9)  return m_cnt;
        if (s == 13) return {16'h0, m_pend, 15'h0};
        return m_reg[s];
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic mreset();
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_cnt = '0; m_vic = 32'd31; m_pend = 1'b0; m_err = 1'b0;
    endtask

    task automatic step(input logic we, input logic [4:0] s, input logic [31:0] d,
                        input logic tk, input logic rt);
        logic [31:0] n_cnt, n_vic;
        logic        n_pend, set_p, clr_m, clr_c, n_err, cnt_ld;
        logic [31:0] n_reg [32];
        int k;
        @(negedge clk);
        wr_en = we; wr_sel = s; wr_data = d; tick = tk; retire = rt;
        for (int i = 0; i < 32; i++) n_reg[i] = m_reg[i];
        n_cnt = m_cnt; n_vic = m_vic; n_err = 1'b0;
        set_p = 1'b0; clr_m = 1'b0; clr_c = 1'b0; cnt_ld = 1'b0;
        k = we ? kind(int'(s)) : 1;
        if (k == 0) n_reg[s] = (m_reg[s] & ~msk(int'(s))) | (d & msk(int'(s)));
        if (k == 0 && s == 5'd0) n_err = d[5];
        if (k == 2) begin n_cnt = d; cnt_ld = 1'b1; end
        if (k == 3) begin if (d == 0) clr_c = 1'b1; else n_err = 1'b1; end
        if (k == 4) n_err = 1'b1;
        if (we && s == 5'd11) clr_m = 1'b1;
        if (tk && !cnt_ld) begin
            n_cnt = m_cnt + 1;
            set_p = (n_cnt == m_reg[11]);
        end
        n_pend = clr_m ? 1'b0 : set_p ? 1'b1 : clr_c ? 1'b0 : m_pend;
        if (we && s == 5'd6) n_vic = 32'd31;
        else if (rt) n_vic = (m_vic <= m_reg[6]) ? 32'd31 : m_vic - 1;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick = 1'b0; retire = 1'b0;
        for (int i = 0; i < 32; i++) m_reg[i] = n_reg[i];
        m_cnt = n_cnt; m_vic = n_vic; m_pend = n_pend; m_err = n_err;
        #1;
        chk(we && kind(int'(s)) == 4 ? "R7 err" : (we && s == 5'd13 ? "R6 err" :
            (we && s == 5'd0 ? "R4 err" : "R5 err")), {63'h0, wr_err}, {63'h0, m_err});
        chk("R9 irq", {63'h0, timer_irq}, {63'h0, m_pend});
    endtask

    task automatic rd(input string tag, input int s);
        rd_sel = 5'(s);
        #1;
        chk(tag, rd_data, sx(mread(s)));
    endtask

    task automatic wr(input int s, input logic [31:0] d);
        step(1'b1, 5'(s), d, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5521));
        mreset();
        #20 rst_n = 1'b1;
        #2;
        // R1 reset state
        for (int s = 0; s < 32; s++) rd("R1 reset", s);
        chk("R1 err", {63'h0, wr_err}, 64'h0);

        // R2 masks, R11 sign extension
        foreach (m_reg[s]) begin
            if (kind(s) == 0 && s != 4 && s != 6 && s != 11) begin
                wr(s, 32'hFFFFFFFF);
                rd("R2 mask", s);
                rd("R11 read", s);
            end
        end
        wr(0, 32'h0000001F); rd("R2 index", 0);
        wr(0, 32'h80000020); rd("R4 index kept", 0);
        // R3 merge
        wr(4, 32'hFFFFFFFF); rd("R3 merge", 4);
        wr(4, 32'h00ABCDEF); rd("R3 merge", 4);
        // R5 dropped writes
        wr(1, 32'h5); wr(8, 32'hFFFF); wr(15, 32'h1234); wr(27, 32'h1); wr(29, 32'hFFFFFFFF);
        rd("R5 victim", 1); rd("R5 fault", 8); rd("R5 ident", 15); rd("R5 cerr", 27); rd("R5 taghi", 29);
        // R7 unlisted
        wr(7, 32'hDEAD); rd("R7 read", 7);
        wr(31, 32'h1); rd("R7 read", 31);
        wr(22, 32'h1); rd("R7 read", 22);
        // R8 counter
        step(1'b1, 5'd9, 32'd10, 1'b1, 1'b0); rd("R8 load", 9);
        step(1'b0, 5'd0, 0, 1'b1, 1'b0); rd("R8 tick", 9);
        // R9 match
        wr(11, 32'd20);
        wr(9, 32'd17);
        for (int i = 0; i < 5; i++) begin step(1'b0, 5'd0, 0, 1'b1, 1'b0); rd("R9 cause", 13); end
        chk("R9 set", {63'h0, timer_irq}, 64'h1);
        // R6 cause
        wr(13, 32'h8000); rd("R6 nonzero", 13);
        wr(13, 32'h0); rd("R6 zero clears", 13);
        wr(9, 32'd19);
        step(1'b1, 5'd13, 32'h0, 1'b1, 1'b0); rd("R9 set beats cause clear", 13);
        wr(9, 32'd19);
        step(1'b1, 5'd11, 32'd20, 1'b1, 1'b0); rd("R9 match write wins", 13);
        wr(9, 32'hFFFFFFFE); step(1'b0, 5'd0, 0, 1'b1, 1'b0); rd("R11 sext count", 9);
        // R10 victim
        wr(6, 32'd28);
        for (int i = 0; i < 6; i++) begin step(1'b0, 5'd0, 0, 1'b0, 1'b1); rd("R10 step", 1); end
        step(1'b0, 5'd0, 0, 1'b0, 1'b1);
        step(1'b1, 5'd6, 32'd0, 1'b0, 1'b1); rd("R10 wired wins", 1);
        wr(6, 32'd40); step(1'b0, 5'd0, 0, 1'b0, 1'b1); rd("R10 high floor", 1);
        wr(6, 32'd0);
        for (int i = 0; i < 40; i++) begin step(1'b0, 5'd0, 0, 1'b0, 1'b1); rd("R10 wrap", 1); end

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [4:0]  s;
            logic [31:0] d;
            logic        we;
            s  = 5'($urandom_range(0, 31));
            we = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 3))
                0:       d = 32'($urandom_range(0, 40));
                1:       d = 32'h0;
                default: d = $urandom();
            endcase
            if (($urandom_range(0, 7) == 0) && s == 5'd9) d = m_reg[11] - 1;
            step(we, s, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            rd("R11 random read", int'($urandom_range(0, 31)));
            rd("R8 random count", 9);
            rd("R10 random victim", 1);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule